// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller for a dynamically scheduled pipeline with a small register file and several functional units. It tracks each unit's instruction through four phases: issue, operand read, execution and result write. Instructions arrive one at a time and in program order, each carrying a unit class, a destination register and two source registers. The scoreboard decides when the instruction leaves issue, when its unit may read operands and when it may write its result back. Execution and completion can finish out of order.

Each functional unit keeps its own status record. The record holds the destination and source registers, the unit expected to produce each pending source, and a ready flag for each source. A register status table maps every register to the unit that will write it. Operand datapaths and arithmetic are outside this block. Each unit reports the end of execution with a one-cycle done pulse. A stalled issue request holds the issue port, so at most one instruction waits there. The default configuration has 8 registers and 3 units.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset no unit is busy. With issue_valid_i low, issue_stall_o, rd_grant_o and wb_grant_o are all zero.
- R2: An instruction stalls while its class's unit is busy. It issues in the cycle after that unit's write-back grant.
- R3: An instruction stalls while any active instruction targets its destination register. It issues in the cycle after that writer's write-back grant.
- R4: When neither source register has a pending writer, rd_grant_o for the unit pulses for exactly one cycle, in the cycle after the issue edge.
- R5: While a source register waits on an earlier-issued unit's result, the read grant is withheld. It is given in the cycle after that producer's write-back grant.
- R6: exec_done_i is taken only after the read grant. Without a conflict, wb_grant_o pulses for one cycle in the cycle after the done pulse, and the unit is free in the next cycle. A unit's read and write grants are never high together.
- R7: The write-back grant is withheld while another unit holds a source operand that is ready but not yet read and names the same register as the destination. It is given in the cycle after that unit's read grant. In the same cycle, no unit reads a register that another unit is writing.
- R8: A class value of NFU or above is not a unit. Such a request keeps issue_stall_o high and produces no grant.
- R9: A later-issued instruction on a shorter-latency unit may write back before an earlier-issued longer one.
- R10: A done pulse to a unit that is not executing is ignored. It causes no write-back grant and does not shorten that unit's next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | An instruction is presented at issue |
| issue_fu_i | input | FU_W | Unit class (index of the functional unit) |
| issue_dst_i | input | REG_W | Destination register |
| issue_src1_i | input | REG_W | First source register |
| issue_src2_i | input | REG_W | Second source register |
| issue_stall_o | output | 1 | The presented instruction cannot issue this cycle |
| rd_grant_o | output | NFU | Per-unit operand read grant |
| exec_done_i | input | NFU | Per-unit end-of-execution pulse |
| wb_grant_o | output | NFU | Per-unit result write grant |

## Verification
The bound checker verifies the conditions that hold on every cycle. These are the structural, destination and bad-class stall rules, single-cycle read and write pulses, a unit being free after its write, exclusion of read and write on one unit, and no read of a register that is being written in the same cycle. Only the bench scenarios can show the timing relations between units. These include the read that follows a producer's write by one cycle, the delayed write that waits for a pending reader, out-of-order completion, and the way a stray done pulse is dropped. The bench drives fixed-latency unit models of 1, 2 and 4 cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_WRITE = 2'd3
  } sb_phase_e;
endpackage

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl #(
  parameter int unsigned NFU  = 3,
  parameter int unsigned FU_W = 2
) (
  input  logic             valid_i,
  input  logic [FU_W-1:0]  fu_i,
  input  logic [NFU-1:0]   busy_i,
  input  logic             dst_pend_i,
  output logic             stall_o,
  output logic [NFU-1:0]   issue_vec_o
);
  logic fu_ok;
  logic fu_busy;

  always_comb begin
    fu_ok   = (32'(fu_i) < NFU);
    fu_busy = 1'b0;
    for (int f = 0; f < int'(NFU); f++)
      if (fu_i == FU_W'(f)) fu_busy = busy_i[f];
  end

  assign stall_o = valid_i && (!fu_ok || fu_busy || dst_pend_i);

  always_comb begin
    issue_vec_o = '0;
    for (int f = 0; f < int'(NFU); f++)
      issue_vec_o[f] = valid_i && !stall_o && (fu_i == FU_W'(f));
  end
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned NFU   = 3,
  parameter int unsigned REG_W = 3,
  parameter int unsigned FU_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [FU_W-1:0]  issue_fu_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src1_i,
  input  logic [REG_W-1:0] src2_i,
  input  logic [NFU-1:0]   wb_vec_i,
  output logic             dst_pend_o,
  output logic             q1_vld_o,
  output logic [FU_W-1:0]  q1_fu_o,
  output logic             q2_vld_o,
  output logic [FU_W-1:0]  q2_fu_o,
  output logic [NREG-1:0]  res_vld_o
);
  logic [NREG-1:0]           res_vld_q;
  logic [NREG-1:0][FU_W-1:0] res_fu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_q <= '0;
      res_fu_q  <= '0;
    end else begin
      for (int r = 0; r < int'(NREG); r++) begin
        for (int f = 0; f < int'(NFU); f++)
          if (wb_vec_i[f] && res_vld_q[r] && res_fu_q[r] == FU_W'(f))
            res_vld_q[r] <= 1'b0;
        if (issue_i && dst_i == REG_W'(r)) begin
          res_vld_q[r] <= 1'b1;
          res_fu_q[r]  <= issue_fu_i;
        end
      end
    end
  end

  // source lookup; a producer writing back this cycle counts as done
  always_comb begin
    dst_pend_o = 1'b0;
    q1_vld_o = 1'b0; q1_fu_o = '0;
    q2_vld_o = 1'b0; q2_fu_o = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      if (dst_i  == REG_W'(r)) dst_pend_o = res_vld_q[r];
      if (src1_i == REG_W'(r)) begin q1_vld_o = res_vld_q[r]; q1_fu_o = res_fu_q[r]; end
      if (src2_i == REG_W'(r)) begin q2_vld_o = res_vld_q[r]; q2_fu_o = res_fu_q[r]; end
    end
    for (int f = 0; f < int'(NFU); f++) begin
      if (wb_vec_i[f] && q1_fu_o == FU_W'(f)) q1_vld_o = 1'b0;
      if (wb_vec_i[f] && q2_fu_o == FU_W'(f)) q2_vld_o = 1'b0;
    end
  end

  assign res_vld_o = res_vld_q;
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int unsigned NFU   = 3,
  parameter int unsigned REG_W = 3,
  parameter int unsigned FU_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src1_i,
  input  logic [REG_W-1:0] src2_i,
  input  logic             q1_vld_i,
  input  logic [FU_W-1:0]  q1_fu_i,
  input  logic             q2_vld_i,
  input  logic [FU_W-1:0]  q2_fu_i,
  input  logic [NFU-1:0]   wb_vec_i,
  input  logic             done_i,
  input  logic             war_block_i,
  output logic             busy_o,
  output logic [REG_W-1:0] fi_o,
  output logic [REG_W-1:0] fj_o,
  output logic [REG_W-1:0] fk_o,
  output logic             rj_o,
  output logic             rk_o,
  output logic             rd_grant_o,
  output logic             wb_grant_o
);
  sb_phase_e        phase_q;
  logic [REG_W-1:0] fi_q, fj_q, fk_q;
  logic             qj_vld_q, qk_vld_q;
  logic [FU_W-1:0]  qj_q, qk_q;
  logic             rj_q, rk_q;
  logic             j_wake, k_wake;

  always_comb begin
    j_wake = 1'b0;
    k_wake = 1'b0;
    for (int g = 0; g < int'(NFU); g++) begin
      if (qj_vld_q && qj_q == FU_W'(g) && wb_vec_i[g]) j_wake = 1'b1;
      if (qk_vld_q && qk_q == FU_W'(g) && wb_vec_i[g]) k_wake = 1'b1;
    end
  end

  assign rd_grant_o = (phase_q == PH_READ) && rj_q && rk_q;
  assign wb_grant_o = (phase_q == PH_WRITE) && !war_block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      fi_q     <= '0;
      fj_q     <= '0;
      fk_q     <= '0;
      qj_vld_q <= 1'b0;
      qk_vld_q <= 1'b0;
      qj_q     <= '0;
      qk_q     <= '0;
      rj_q     <= 1'b0;
      rk_q     <= 1'b0;
    end else if (issue_i) begin
      phase_q  <= PH_READ;
      fi_q     <= dst_i;
      fj_q     <= src1_i;
      fk_q     <= src2_i;
      qj_vld_q <= q1_vld_i;
      qj_q     <= q1_fu_i;
      qk_vld_q <= q2_vld_i;
      qk_q     <= q2_fu_i;
      rj_q     <= !q1_vld_i;
      rk_q     <= !q2_vld_i;
    end else begin
      unique case (phase_q)
        PH_READ: begin
          if (rd_grant_o) begin
            phase_q <= PH_EXEC;
            rj_q    <= 1'b0;
            rk_q    <= 1'b0;
          end else begin
            if (j_wake) begin rj_q <= 1'b1; qj_vld_q <= 1'b0; end
            if (k_wake) begin rk_q <= 1'b1; qk_vld_q <= 1'b0; end
          end
        end
        PH_EXEC:  if (done_i) phase_q <= PH_WRITE;
        PH_WRITE: if (wb_grant_o) phase_q <= PH_IDLE;
        default:  ;
      endcase
    end
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign fi_o   = fi_q;
  assign fj_o   = fj_q;
  assign fk_o   = fk_q;
  assign rj_o   = rj_q;
  assign rk_o   = rk_q;
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned NFU   = 3,
  parameter int unsigned REG_W = $clog2(NREG),
  parameter int unsigned FU_W  = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic [FU_W-1:0]  issue_fu_i,
  input  logic [REG_W-1:0] issue_dst_i,
  input  logic [REG_W-1:0] issue_src1_i,
  input  logic [REG_W-1:0] issue_src2_i,
  output logic             issue_stall_o,
  output logic [NFU-1:0]   rd_grant_o,
  input  logic [NFU-1:0]   exec_done_i,
  output logic [NFU-1:0]   wb_grant_o
);
  logic [NFU-1:0]            busy;
  logic [NFU-1:0]            issue_vec;
  logic [NFU-1:0]            war_block;
  logic [NFU-1:0]            rj, rk;
  logic [NFU-1:0][REG_W-1:0] fi, fj, fk;
  logic [NREG-1:0]           res_vld;
  logic                      dst_pend;
  logic                      q1_vld, q2_vld;
  logic [FU_W-1:0]           q1_fu, q2_fu;

  sb_issue_ctrl #(.NFU(NFU), .FU_W(FU_W)) u_issue (
    .valid_i     (issue_valid_i),
    .fu_i        (issue_fu_i),
    .busy_i      (busy),
    .dst_pend_i  (dst_pend),
    .stall_o     (issue_stall_o),
    .issue_vec_o (issue_vec)
  );

  sb_reg_status #(.NREG(NREG), .NFU(NFU), .REG_W(REG_W), .FU_W(FU_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (|issue_vec),
    .issue_fu_i (issue_fu_i),
    .dst_i      (issue_dst_i),
    .src1_i     (issue_src1_i),
    .src2_i     (issue_src2_i),
    .wb_vec_i   (wb_grant_o),
    .dst_pend_o (dst_pend),
    .q1_vld_o   (q1_vld),
    .q1_fu_o    (q1_fu),
    .q2_vld_o   (q2_vld),
    .q2_fu_o    (q2_fu),
    .res_vld_o  (res_vld)
  );

  // write-after-read: another unit still holds an unread ready operand naming our destination
  always_comb begin
    war_block = '0;
    for (int f = 0; f < int'(NFU); f++)
      for (int g = 0; g < int'(NFU); g++)
        if (g != f && ((rj[g] && fj[g] == fi[f]) || (rk[g] && fk[g] == fi[f])))
          war_block[f] = 1'b1;
  end

  for (genvar f = 0; f < int'(NFU); f++) begin : g_fu
    sb_fu_entry #(.NFU(NFU), .REG_W(REG_W), .FU_W(FU_W)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .issue_i     (issue_vec[f]),
      .dst_i       (issue_dst_i),
      .src1_i      (issue_src1_i),
      .src2_i      (issue_src2_i),
      .q1_vld_i    (q1_vld),
      .q1_fu_i     (q1_fu),
      .q2_vld_i    (q2_vld),
      .q2_fu_i     (q2_fu),
      .wb_vec_i    (wb_grant_o),
      .done_i      (exec_done_i[f]),
      .war_block_i (war_block[f]),
      .busy_o      (busy[f]),
      .fi_o        (fi[f]),
      .fj_o        (fj[f]),
      .fk_o        (fk[f]),
      .rj_o        (rj[f]),
      .rk_o        (rk[f]),
      .rd_grant_o  (rd_grant_o[f]),
      .wb_grant_o  (wb_grant_o[f])
    );
  end
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned NFU   = 3,
  parameter int unsigned REG_W = 3,
  parameter int unsigned FU_W  = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      issue_valid_i,
  input logic [FU_W-1:0]           issue_fu_i,
  input logic [REG_W-1:0]          issue_dst_i,
  input logic                      issue_stall_o,
  input logic [NFU-1:0]            rd_grant_o,
  input logic [NFU-1:0]            wb_grant_o,
  input logic [NFU-1:0]            busy,
  input logic [NREG-1:0]           res_vld,
  input logic [NFU-1:0][REG_W-1:0] fi,
  input logic [NFU-1:0][REG_W-1:0] fj,
  input logic [NFU-1:0][REG_W-1:0] fk
);
  a_r8_bad_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && (32'(issue_fu_i) >= NFU) |-> issue_stall_o);

  for (genvar r = 0; r < int'(NREG); r++) begin : g_reg
    a_r3_waw_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_i && issue_dst_i == REG_W'(r) && res_vld[r] |-> issue_stall_o);
  end

  for (genvar f = 0; f < int'(NFU); f++) begin : g_f
    a_r2_busy_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_i && issue_fu_i == FU_W'(f) && busy[f] |-> issue_stall_o);
    a_r4_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_grant_o[f] |=> !rd_grant_o[f]);
    a_r6_wb_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_grant_o[f] |=> !wb_grant_o[f] && !busy[f]);
    a_r6_rd_wb_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_grant_o[f] && wb_grant_o[f]));
    for (genvar g = 0; g < int'(NFU); g++) begin : g_g
      if (g != f) begin : g_pair
        a_r7_no_read_of_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
          rd_grant_o[g] && wb_grant_o[f] |-> fj[g] != fi[f] && fk[g] != fi[f]);
      end
    end
  end
endmodule

bind sb_scoreboard sb_scoreboard_chk #(
  .NREG(NREG), .NFU(NFU), .REG_W(REG_W), .FU_W(FU_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_fu_i    (issue_fu_i),
  .issue_dst_i   (issue_dst_i),
  .issue_stall_o (issue_stall_o),
  .rd_grant_o    (rd_grant_o),
  .wb_grant_o    (wb_grant_o),
  .busy          (busy),
  .res_vld       (res_vld),
  .fi            (fi),
  .fj            (fj),
  .fk            (fk)
);

// File: tb/sb_scoreboard_test.sv
`timescale 1ns/1ps
module sb_scoreboard_test;
  localparam int NREG = 8;
  localparam int NFU  = 3;
  localparam int REG_W = 3;
  localparam int FU_W  = 2;
  localparam int LAT [NFU] = '{1, 2, 4};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue_valid = 1'b0;
  logic [FU_W-1:0]  issue_fu = '0;
  logic [REG_W-1:0] issue_dst = '0, issue_src1 = '0, issue_src2 = '0;
  logic             issue_stall;
  logic [NFU-1:0]   rd_grant, wb_grant, exec_done;
  logic [NFU-1:0]   mdone = '0, inj_done = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int cnt [NFU];
  int rd_cyc [NFU];
  int wb_cyc [NFU];
  int wb_seen [NFU];

  always #2 clk = ~clk;

  assign exec_done = mdone | inj_done;

  sb_scoreboard #(.NREG(NREG), .NFU(NFU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(issue_valid), .issue_fu_i(issue_fu),
    .issue_dst_i(issue_dst), .issue_src1_i(issue_src1), .issue_src2_i(issue_src2),
    .issue_stall_o(issue_stall), .rd_grant_o(rd_grant), .exec_done_i(exec_done),
    .wb_grant_o(wb_grant)
  );

  // fixed-latency unit models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NFU; f++) cnt[f] <= 0;
      mdone <= '0;
    end else begin
      cyc <= cyc + 1;
      for (int f = 0; f < NFU; f++) begin
        if (rd_grant[f]) cnt[f] <= LAT[f];
        else if (cnt[f] > 0) cnt[f] <= cnt[f] - 1;
        mdone[f] <= (cnt[f] == 1) && !rd_grant[f];
      end
    end
  end

  always @(negedge clk) begin
    for (int f = 0; f < NFU; f++) begin
      if (rd_grant[f]) rd_cyc[f] = cyc;
      if (wb_grant[f]) begin wb_cyc[f] = cyc; wb_seen[f]++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_marks();
    for (int f = 0; f < NFU; f++) begin rd_cyc[f] = -1; wb_cyc[f] = -1; wb_seen[f] = 0; end
  endtask

  task automatic drain();
    repeat (16) @(negedge clk);
  endtask

  task automatic do_issue(input int fu, input int dst, input int s1, input int s2,
                          output int icyc, output int stalled);
    @(negedge clk);
    issue_fu = FU_W'(fu); issue_dst = REG_W'(dst);
    issue_src1 = REG_W'(s1); issue_src2 = REG_W'(s2);
    issue_valid = 1'b1;
    stalled = 0;
    #1;
    while (issue_stall) begin
      @(negedge clk); #1;
      stalled++;
    end
    icyc = cyc;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(issue_stall == 1'b0, "R1 stall", int'(issue_stall), 0);
    chk(rd_grant == '0, "R1 rd_grant", int'(rd_grant), 0);
    chk(wb_grant == '0, "R1 wb_grant", int'(wb_grant), 0);
  endtask

  task automatic t_basic();
    int ic, st;
    clear_marks();
    do_issue(0, 1, 2, 3, ic, st);
    chk(st == 0, "R4 no stall", st, 0);
    drain();
    chk(rd_cyc[0] == ic + 1, "R4 read cycle", rd_cyc[0], ic + 1);
    chk(wb_cyc[0] == ic + 3 + LAT[0], "R6 write cycle", wb_cyc[0], ic + 3 + LAT[0]);
    chk(wb_seen[0] == 1, "R6 single write", wb_seen[0], 1);
  endtask

  task automatic t_struct();
    int i1, i2, st, first_wb;
    clear_marks();
    do_issue(1, 2, 0, 0, i1, st);
    do_issue(1, 3, 0, 0, i2, st);
    first_wb = wb_cyc[1];
    chk(st > 0, "R2 stalled on busy unit", st, 1);
    chk(i2 == first_wb + 1, "R2 issue after write", i2, first_wb + 1);
    drain();
  endtask

  task automatic t_waw();
    int i1, i2, st;
    clear_marks();
    do_issue(2, 4, 0, 0, i1, st);
    do_issue(0, 4, 1, 1, i2, st);
    chk(st > 0, "R3 stalled on pending dst", st, 1);
    chk(i2 == wb_cyc[2] + 1, "R3 issue after writer", i2, wb_cyc[2] + 1);
    drain();
  endtask

  task automatic t_raw();
    int i1, i2, st;
    clear_marks();
    do_issue(2, 5, 0, 0, i1, st);
    do_issue(0, 6, 5, 0, i2, st);
    chk(st == 0, "R5 consumer issues at once", st, 0);
    drain();
    chk(rd_cyc[0] == wb_cyc[2] + 1, "R5 read after producer write", rd_cyc[0], wb_cyc[2] + 1);
  endtask

  task automatic t_ooo();
    int i1, i2, st;
    clear_marks();
    do_issue(2, 1, 0, 0, i1, st);
    do_issue(0, 2, 0, 0, i2, st);
    drain();
    chk(wb_cyc[0] < wb_cyc[2], "R9 later short op writes first", wb_cyc[0], wb_cyc[2]);
  endtask

  task automatic t_war();
    int i1, i2, i3, st;
    clear_marks();
    do_issue(2, 5, 0, 0, i1, st);
    do_issue(1, 6, 7, 5, i2, st);
    do_issue(0, 7, 0, 0, i3, st);
    drain();
    chk(wb_cyc[0] > i3 + 3 + LAT[0], "R7 write delayed", wb_cyc[0], i3 + 4 + LAT[0]);
    chk(wb_cyc[0] == rd_cyc[1] + 1, "R7 write after reader", wb_cyc[0], rd_cyc[1] + 1);
    chk(rd_cyc[1] == wb_cyc[2] + 1, "R5 reader wakes", rd_cyc[1], wb_cyc[2] + 1);
  endtask

  task automatic t_bad_class();
    int hi = 0;
    clear_marks();
    @(negedge clk);
    issue_fu = 2'd3; issue_dst = 3'd1; issue_src1 = 3'd0; issue_src2 = 3'd0;
    issue_valid = 1'b1;
    repeat (6) begin
      @(negedge clk); #1;
      if (issue_stall) hi++;
    end
    issue_valid = 1'b0;
    drain();
    chk(hi == 6, "R8 stall held", hi, 6);
    chk(rd_cyc[0] < 0 && rd_cyc[1] < 0 && rd_cyc[2] < 0, "R8 no read grant", 0, -1);
    chk(wb_seen[0] + wb_seen[1] + wb_seen[2] == 0, "R8 no write grant",
        wb_seen[0] + wb_seen[1] + wb_seen[2], 0);
  endtask

  task automatic t_stray_done();
    int ic, st;
    clear_marks();
    @(negedge clk); inj_done[1] = 1'b1;
    @(negedge clk); inj_done[1] = 1'b0;
    repeat (4) @(negedge clk);
    chk(wb_seen[1] == 0, "R10 stray done ignored", wb_seen[1], 0);
    do_issue(1, 3, 0, 0, ic, st);
    drain();
    chk(wb_cyc[1] == ic + 3 + LAT[1], "R10 latency intact", wb_cyc[1], ic + 3 + LAT[1]);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_marks();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_struct();
    t_waw();
    t_raw();
    t_ooo();
    t_war();
    t_bad_class();
    t_stray_done();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule